// File: doc/BRIEF.md
# Load-Use Stall Scoreboard

This block keeps score of load-use hazards for an in-order core model. It remembers which general registers are the destinations of loads that have just completed, and for every instruction it works out how many cycles the instruction costs: the base cycle count supplied with the instruction, plus one cycle for each source register that is still waiting on such a load. It also keeps two running totals: all cycles spent, and the cycles lost to load-use stalls.

Each instruction is framed by a begin strobe and a later end strobe. With the begin strobe the caller presents the unit kind, two source register indices with valid bits, a load destination index and the base cycle count. The hazard check runs against the active hazard mask at that moment. Loads record their destinations in a pending mask, and that mask becomes the active hazard mask only when the instruction ends. A load therefore exposes its destination to exactly the one instruction that follows it.

Top module: `lduse_scoreboard`

## Requirements
- R1: A synchronous active-high reset clears both masks, `insn_cycles`, `total_cycles` and `stall_cycles`. An instruction issued right after reset sees no hazard.
- R2: The begin strobe clears the pending mask. A load that begins but never ends marks nothing that a later instruction can see.
- R3: A load (unit code 1) sets its destination's bit in the pending mask. On the end strobe the active mask is replaced by the pending mask, so a hazard lasts for exactly the next instruction.
- R4: Each checked source whose bit is set in the active mask adds one cycle to the instruction and one to `stall_cycles`. If the same register is named in both checked sources, it counts twice.
- R5: Exec (code 0) and store (code 2) check both source A and source B.
- R6: Load (code 1) and branch (code 3) check only source A. Source B is ignored.
- R7: Load-multiple (code 4), store-multiple (code 5) and the unused codes 6 and 7 check nothing. Their cycle count equals the base count.
- R8: A source whose valid bit is low is never checked and adds no stall.
- R9: `insn_cycles` (base + stalls) is registered at the begin strobe and is readable from the next cycle. On the end strobe it is added to `total_cycles`. Both 32-bit counters wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| insn_begin | input | 1 | Instruction start strobe; samples the fields below |
| insn_end | input | 1 | Instruction end strobe |
| unit_kind | input | 3 | 0 exec, 1 load, 2 store, 3 branch, 4 load-multiple, 5 store-multiple |
| src_a_idx | input | 4 | Source A register index (address register for loads) |
| src_a_vld | input | 1 | Source A valid |
| src_b_idx | input | 4 | Source B register index |
| src_b_vld | input | 1 | Source B valid |
| ld_dst_idx | input | 4 | Load destination register index |
| base_cycles | input | 8 | Base cycle count of the instruction |
| insn_cycles | output | 32 | Cycles of the current instruction |
| total_cycles | output | 32 | Running total of instruction cycles |
| stall_cycles | output | 32 | Running total of load-use stall cycles |

## Verification
The hardest situation to reach from the ports is a load that begins but never ends. Its destination is written into the pending mask, but it must never reach the active mask. The bench issues such a load and then starts an exec instruction that reads the same register, and expects no stall. It also checks that the orphaned load added nothing to the total. A vector table covers the other cases by setting a hazard with one load and reading it back through every unit kind, with the valid bit both set and cleared.

// File: rtl/lsb_pkg.sv
package lsb_pkg;
  typedef enum logic [2:0] {
    UK_EXEC   = 3'd0,
    UK_LOAD   = 3'd1,
    UK_STORE  = 3'd2,
    UK_BRANCH = 3'd3,
    UK_LDM    = 3'd4,
    UK_STM    = 3'd5
  } unit_kind_e;

  // source A is examined by exec, load, store and branch
  function automatic logic uses_src_a(logic [2:0] kind);
    return kind <= 3'd3;
  endfunction

  // source B is examined only by exec and store
  function automatic logic uses_src_b(logic [2:0] kind);
    return (kind == UK_EXEC) || (kind == UK_STORE);
  endfunction

  function automatic logic [1:0] sum_hits(logic [1:0] hit);
    return {1'b0, hit[0]} + {1'b0, hit[1]};
  endfunction
endpackage

// File: rtl/lsb_mask_track.sv
module lsb_mask_track #(
  parameter int NREG  = 16,
  parameter int IDX_W = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             insn_begin,
  input  logic             insn_end,
  input  logic             mark_load,
  input  logic [IDX_W-1:0] dst_idx,
  output logic [NREG-1:0]  active_mask,
  output logic [NREG-1:0]  pending_mask
);
  logic [NREG-1:0] dst_onehot;
  assign dst_onehot = NREG'(1) << dst_idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      pending_mask <= '0;
      active_mask  <= '0;
    end else begin
      if (insn_begin)
        pending_mask <= mark_load ? dst_onehot : '0;
      if (insn_end)
        active_mask <= pending_mask;
    end
  end

  p_begin_clears_r2: assert property (@(posedge clk) disable iff (rst)
    insn_begin && !mark_load |=> pending_mask == '0);
  p_load_marks_r3: assert property (@(posedge clk) disable iff (rst)
    insn_begin && mark_load |=> $countones(pending_mask) == 1 && pending_mask[$past(dst_idx)]);
  p_end_promotes_r3: assert property (@(posedge clk) disable iff (rst)
    insn_end |=> active_mask == $past(pending_mask));
  p_active_holds_r3: assert property (@(posedge clk) disable iff (rst)
    !insn_end |=> $stable(active_mask));
endmodule

// File: rtl/lsb_hazard_check.sv
module lsb_hazard_check
  import lsb_pkg::*;
#(
  parameter int NREG  = 16,
  parameter int IDX_W = $clog2(NREG)
) (
  input  logic [NREG-1:0]  active_mask,
  input  logic [2:0]       unit_kind,
  input  logic [IDX_W-1:0] src_a_idx,
  input  logic             src_a_vld,
  input  logic [IDX_W-1:0] src_b_idx,
  input  logic             src_b_vld,
  output logic [1:0]       hits
);
  localparam int NSRC = 2;

  logic [IDX_W-1:0] idx [NSRC];
  logic [NSRC-1:0]  enabled;
  logic [NSRC-1:0]  hit;

  assign idx[0]     = src_a_idx;
  assign idx[1]     = src_b_idx;
  assign enabled[0] = src_a_vld && uses_src_a(unit_kind);
  assign enabled[1] = src_b_vld && uses_src_b(unit_kind);

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    assign hit[s] = enabled[s] && active_mask[idx[s]];
  end

  assign hits = sum_hits(hit);
endmodule

// File: rtl/lsb_counters.sv
module lsb_counters #(
  parameter int BASE_W = 8,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              insn_begin,
  input  logic              insn_end,
  input  logic [BASE_W-1:0] base_cycles,
  input  logic [1:0]        hits,
  output logic [CNT_W-1:0]  insn_cycles,
  output logic [CNT_W-1:0]  total_cycles,
  output logic [CNT_W-1:0]  stall_cycles
);
  logic [CNT_W-1:0] cyc_next;
  assign cyc_next = CNT_W'(base_cycles) + CNT_W'(hits);

  always_ff @(posedge clk) begin
    if (rst) begin
      insn_cycles  <= '0;
      total_cycles <= '0;
      stall_cycles <= '0;
    end else begin
      if (insn_begin) begin
        insn_cycles  <= cyc_next;
        stall_cycles <= stall_cycles + CNT_W'(hits);
      end
      if (insn_end)
        total_cycles <= total_cycles + insn_cycles;
    end
  end

  p_stall_bound_r4: assert property (@(posedge clk) disable iff (rst)
    insn_begin |=> (stall_cycles - $past(stall_cycles)) <= CNT_W'(2));
  p_stall_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    !insn_begin |=> $stable(stall_cycles));
  p_cycles_floor_r9: assert property (@(posedge clk) disable iff (rst)
    insn_begin |=> insn_cycles >= CNT_W'($past(base_cycles)));
  p_total_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    !insn_end |=> $stable(total_cycles));
  p_total_step_r9: assert property (@(posedge clk) disable iff (rst)
    insn_end && !insn_begin |=> total_cycles == $past(total_cycles) + $past(insn_cycles));
endmodule

// File: rtl/lduse_scoreboard.sv
module lduse_scoreboard
  import lsb_pkg::*;
#(
  parameter int NREG   = 16,
  parameter int BASE_W = 8,
  parameter int CNT_W  = 32,
  localparam int IDX_W = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              insn_begin,
  input  logic              insn_end,
  input  logic [2:0]        unit_kind,
  input  logic [IDX_W-1:0]  src_a_idx,
  input  logic              src_a_vld,
  input  logic [IDX_W-1:0]  src_b_idx,
  input  logic              src_b_vld,
  input  logic [IDX_W-1:0]  ld_dst_idx,
  input  logic [BASE_W-1:0] base_cycles,
  output logic [CNT_W-1:0]  insn_cycles,
  output logic [CNT_W-1:0]  total_cycles,
  output logic [CNT_W-1:0]  stall_cycles
);
  logic [NREG-1:0] active_mask;
  logic [NREG-1:0] pending_mask;
  logic [1:0]      hits;
  logic            is_load;
  logic            is_multi;

  assign is_load  = unit_kind == UK_LOAD;
  assign is_multi = unit_kind >= UK_LDM;

  lsb_mask_track #(.NREG(NREG)) u_masks (
    .clk          (clk),
    .rst          (rst),
    .insn_begin   (insn_begin),
    .insn_end     (insn_end),
    .mark_load    (is_load),
    .dst_idx      (ld_dst_idx),
    .active_mask  (active_mask),
    .pending_mask (pending_mask)
  );

  lsb_hazard_check #(.NREG(NREG)) u_check (
    .active_mask (active_mask),
    .unit_kind   (unit_kind),
    .src_a_idx   (src_a_idx),
    .src_a_vld   (src_a_vld),
    .src_b_idx   (src_b_idx),
    .src_b_vld   (src_b_vld),
    .hits        (hits)
  );

  lsb_counters #(.BASE_W(BASE_W), .CNT_W(CNT_W)) u_cnt (
    .clk          (clk),
    .rst          (rst),
    .insn_begin   (insn_begin),
    .insn_end     (insn_end),
    .base_cycles  (base_cycles),
    .hits         (hits),
    .insn_cycles  (insn_cycles),
    .total_cycles (total_cycles),
    .stall_cycles (stall_cycles)
  );

  p_multi_no_stall_r7: assert property (@(posedge clk) disable iff (rst)
    insn_begin && is_multi |=> insn_cycles == CNT_W'($past(base_cycles)));
  p_invalid_no_stall_r8: assert property (@(posedge clk) disable iff (rst)
    insn_begin && !src_a_vld && !src_b_vld |=> $stable(stall_cycles));
  p_reset_clears_r1: assert property (@(posedge clk)
    rst |=> insn_cycles == '0 && total_cycles == '0 && stall_cycles == '0);
endmodule

// File: tb/lduse_scoreboard_bench.sv
`timescale 1ns/1ps
module lduse_scoreboard_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        insn_begin = 1'b0;
  logic        insn_end = 1'b0;
  logic [2:0]  unit_kind = 3'd0;
  logic [3:0]  src_a_idx = 4'd0;
  logic        src_a_vld = 1'b0;
  logic [3:0]  src_b_idx = 4'd0;
  logic        src_b_vld = 1'b0;
  logic [3:0]  ld_dst_idx = 4'd0;
  logic [7:0]  base_cycles = 8'd0;
  logic [31:0] insn_cycles, total_cycles, stall_cycles;

  int checks = 0;
  int errors = 0;
  logic [31:0] exp_total = 0;
  logic [31:0] exp_stall = 0;

  always #2.5 clk = ~clk;

  lduse_scoreboard u_lduse_scoreboard (
    .clk(clk), .rst(rst), .insn_begin(insn_begin), .insn_end(insn_end),
    .unit_kind(unit_kind), .src_a_idx(src_a_idx), .src_a_vld(src_a_vld),
    .src_b_idx(src_b_idx), .src_b_vld(src_b_vld), .ld_dst_idx(ld_dst_idx),
    .base_cycles(base_cycles), .insn_cycles(insn_cycles),
    .total_cycles(total_cycles), .stall_cycles(stall_cycles)
  );

  // {kind[3], a[4], a_vld, b[4], b_vld, dst[4], base[8], expected cycles[8]}
  localparam int NV = 20;
  localparam logic [32:0] VEC [NV] = '{
    {3'd1, 4'd1, 1'b1, 4'd0, 1'b0, 4'd5,  8'd2, 8'd2},  // R3 load marks r5
    {3'd0, 4'd5, 1'b1, 4'd6, 1'b1, 4'd0,  8'd1, 8'd2},  // R4 R5 exec A hits
    {3'd0, 4'd5, 1'b1, 4'd5, 1'b1, 4'd0,  8'd1, 8'd1},  // R3 hazard gone
    {3'd1, 4'd2, 1'b1, 4'd0, 1'b0, 4'd7,  8'd3, 8'd3},
    {3'd2, 4'd3, 1'b1, 4'd7, 1'b1, 4'd0,  8'd1, 8'd2},  // R5 store B hits
    {3'd1, 4'd0, 1'b1, 4'd0, 1'b0, 4'd7,  8'd2, 8'd2},
    {3'd1, 4'd7, 1'b1, 4'd7, 1'b1, 4'd9,  8'd2, 8'd3},  // R6 load: A only
    {3'd3, 4'd4, 1'b1, 4'd9, 1'b1, 4'd0,  8'd1, 8'd1},  // R6 branch ignores B
    {3'd1, 4'd0, 1'b0, 4'd0, 1'b0, 4'd9,  8'd2, 8'd2},
    {3'd3, 4'd9, 1'b1, 4'd0, 1'b0, 4'd0,  8'd1, 8'd2},  // R6 branch A hits
    {3'd1, 4'd0, 1'b0, 4'd0, 1'b0, 4'd3,  8'd2, 8'd2},
    {3'd0, 4'd3, 1'b1, 4'd3, 1'b1, 4'd0,  8'd1, 8'd3},  // R4 counts twice
    {3'd1, 4'd0, 1'b0, 4'd0, 1'b0, 4'd4,  8'd2, 8'd2},
    {3'd4, 4'd4, 1'b1, 4'd4, 1'b1, 4'd0,  8'd5, 8'd5},  // R7 load-multiple
    {3'd1, 4'd0, 1'b0, 4'd0, 1'b0, 4'd8,  8'd2, 8'd2},
    {3'd0, 4'd8, 1'b0, 4'd8, 1'b0, 4'd0,  8'd1, 8'd1},  // R8 invalid
    {3'd1, 4'd0, 1'b0, 4'd0, 1'b0, 4'd8,  8'd2, 8'd2},
    {3'd5, 4'd8, 1'b1, 4'd8, 1'b1, 4'd0,  8'd4, 8'd4},  // R7 store-multiple
    {3'd1, 4'd0, 1'b0, 4'd0, 1'b0, 4'd15, 8'd2, 8'd2},
    {3'd0, 4'd15,1'b1, 4'd0, 1'b1, 4'd0,  8'd1, 8'd2}   // R4 top index
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(input logic [32:0] v);
    unit_kind   = v[32:30];
    src_a_idx   = v[29:26];
    src_a_vld   = v[25];
    src_b_idx   = v[24:21];
    src_b_vld   = v[20];
    ld_dst_idx  = v[19:16];
    base_cycles = v[15:8];
  endtask

  // full instruction: begin, then end next cycle
  task automatic run_insn(input string req, input logic [32:0] v);
    @(negedge clk);
    drive(v);
    insn_begin = 1'b1;
    @(negedge clk);
    insn_begin = 1'b0;
    insn_end = 1'b1;
    check({req, " insn_cycles"}, insn_cycles, 32'(v[7:0]));
    exp_stall += 32'(v[7:0]) - 32'(v[15:8]);
    exp_total += 32'(v[7:0]);
    @(negedge clk);
    insn_end = 1'b0;
    check({req, " R9 total"}, total_cycles, exp_total);
    check({req, " R4 stall"}, stall_cycles, exp_stall);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 reset insn", insn_cycles, 0);
    check("R1 reset total", total_cycles, 0);
    check("R1 reset stall", stall_cycles, 0);

    for (int i = 0; i < NV; i++) run_insn($sformatf("vec%0d", i), VEC[i]);

    // R2: load begins, never ends; next exec reads its destination
    @(negedge clk);
    drive({3'd1, 4'd0, 1'b0, 4'd0, 1'b0, 4'd10, 8'd2, 8'd2});
    insn_begin = 1'b1;
    @(negedge clk);
    drive({3'd0, 4'd10, 1'b1, 4'd10, 1'b1, 4'd0, 8'd1, 8'd1});
    @(negedge clk);
    insn_begin = 1'b0;
    check("R2 orphan load no stall", insn_cycles, 1);
    insn_end = 1'b1;
    @(negedge clk);
    insn_end = 1'b0;
    exp_total += 1;
    check("R2 orphan not totalled", total_cycles, exp_total);
    check("R2 stall unchanged", stall_cycles, exp_stall);

    // R1: reset with a live hazard on r6
    run_insn("R1 setup", {3'd1, 4'd0, 1'b0, 4'd0, 1'b0, 4'd6, 8'd2, 8'd2});
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("R1 mid reset total", total_cycles, 0);
    check("R1 mid reset stall", stall_cycles, 0);
    check("R1 mid reset insn", insn_cycles, 0);
    exp_total = 0;
    exp_stall = 0;
    run_insn("R1 hazard cleared", {3'd0, 4'd6, 1'b1, 4'd6, 1'b1, 4'd0, 8'd1, 8'd1});

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule